// File: doc/BRIEF.md
# Receive Buffer with Interrupt Status

This block holds words delivered by a serial receive shifter until the processor reads them. It is a first-in, first-out store of eight 16-bit words. The shifter offers a word with a one-cycle push strobe, and the processor takes the oldest word with a one-cycle read strobe. The read data port always shows the oldest stored word, and it shows zero while the store is empty.

Around the store sit four interrupt sources:
- a service request while the store is at least half full;
- a sticky time-out when data has sat unread through 32 idle serial bit periods;
- a sticky overrun when a word arrives with nowhere to go;
- an end-of-transmission level taken from the transmit side.

Each source has a raw flag, a mask bit and a masked flag. A single interrupt line is the OR of the masked flags. The two sticky flags are cleared by writing one to their clear bit.

Flag bit positions are the same on every 4-bit interrupt vector: bit 0 is the service request, bit 1 the time-out, bit 2 the overrun and bit 3 the end-of-transmission.

Top module: `rx_status_fifo`

## Requirements
- R1: Words leave in the order they were accepted. While the store holds data, `rd_data` shows the oldest word, and it holds up to 8 words of 16 bits.
- R2: While the store is empty, `rd_data` reads 0. A read strobe while empty changes nothing, so the next word pushed is the next word read.
- R3: Raw bit 0 (service) is high exactly when the store holds 4 or more words.
- R4: A push while the store is full and no read is taken in the same cycle discards the word and sets raw bit 2 (overrun). Bit 2 stays set until it is cleared.
- R5: While the store is full, a push and a read in the same cycle both take effect, and overrun does not set.
- R6: Raw bit 1 (time-out) sets in the clock of the 32nd `bit_tick` counted while all of these hold: the store is non-empty, `line_idle` is high, and there is no push or read. The count restarts on a push, on a read, on `line_idle` low, or on an empty store.
- R7: Raw bit 3 (end-of-transmission) is high exactly when `tx_done` and `tx_empty` are both high.
- R8: A one in `irq_clr` bit 1 or bit 2 clears that sticky flag on the next clock. Clear bits 0 and 3 have no effect, because those flags follow their conditions.
- R9: `irq_masked` is `irq_raw` AND `irq_mask`, and `irq` is high when any masked bit is high.
- R10: After reset the store is empty and every raw flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Shifter offers a word this cycle |
| push_data | input | 16 | Word from the shifter |
| rd_en | input | 1 | Processor takes the oldest word this cycle |
| rd_data | output | 16 | Oldest stored word, 0 when empty |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| line_idle | input | 1 | Serial line carries no transfer |
| tx_done | input | 1 | Transmit side finished its last frame |
| tx_empty | input | 1 | Transmit store holds no data |
| irq_mask | input | 4 | Enable per flag (bit 0 service, 1 time-out, 2 overrun, 3 end) |
| irq_clr | input | 4 | Write-one-to-clear strobes, one cycle |
| irq_raw | output | 4 | Unmasked flags |
| irq_masked | output | 4 | Flags after masking |
| irq | output | 1 | OR of masked flags |

## Verification
The assertions take the push and read strobes to be single-cycle and synchronous, and they treat `bit_tick` as a pulse. They also assume the store's occupancy only moves through those strobes, so that "full" and "empty" at the ports mean what the requirements say. The bench drives every strobe for exactly one clock, separates bit ticks by an idle cycle, and changes inputs shortly after a rising edge. It keeps `line_idle` low outside the time-out scenario, so that no stray time-out flag disturbs the other checks.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the receive buffer: interrupt flag positions.
// Assumes all 4-bit interrupt vectors use this bit ordering.
package rxq_pkg;
    localparam int IRQ_N = 4;
    typedef enum int unsigned {
        IRQ_SVC = 0,
        IRQ_TMO = 1,
        IRQ_OVR = 2,
        IRQ_EOT = 3
    } irq_idx_e;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
// Circular word store with occupancy count.
// A read on empty is ignored and shows zero. A push on full with no
// same-cycle read is dropped and reported through 'drop'.
// Assumes DEPTH >= 2.
module rxq_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             empty, full, do_pop, do_push;

    // Decode the accepted operations for this cycle.
    always_comb begin
        empty   = (occ == '0);
        full    = (occ == CW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && full && !do_pop;
        rd_data = empty ? '0 : mem[rd_ptr];
    end

    // Write accepted words into storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/rxq_idle_timer.sv
`timescale 1ns/1ps
// Counts bit periods while data waits unread on an idle line.
// 'expire' pulses on the tick that completes TO_BITS periods. The count
// then saturates until something restarts it.
// Assumes 'tick' is a one-cycle pulse.
module rxq_idle_timer #(
    parameter int TO_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic idle,
    input  logic has_data,
    input  logic activity,
    output logic expire
);
    localparam int TW = $clog2(TO_BITS+1);

    logic [TW-1:0] cnt;
    logic          armed;

    // Conditions under which the count may advance.
    always_comb begin
        armed  = idle && has_data && !activity;
        expire = tick && armed && (cnt == TW'(TO_BITS-1));
    end

    // Count idle bit periods, restart on any disturbance.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cnt <= '0;
        end else if (tick && cnt != TW'(TO_BITS)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxq_irq_flags.sv
`timescale 1ns/1ps
// Interrupt flag bank. Service and end-of-transmission follow their
// conditions. Time-out and overrun are sticky, with write-one-to-clear.
// A set in the same cycle as a clear wins.
module rxq_irq_flags
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_lvl,
    input  logic             tmo_set,
    input  logic             ovr_set,
    input  logic             eot_lvl,
    input  logic [IRQ_N-1:0] clr,
    input  logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] raw,
    output logic [IRQ_N-1:0] masked,
    output logic             irq
);
    logic tmo_q, ovr_q;

    // Sticky flags with clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            tmo_q <= tmo_set || (tmo_q && !clr[IRQ_TMO]);
            ovr_q <= ovr_set || (ovr_q && !clr[IRQ_OVR]);
        end
    end

    // Assemble the vectors and the combined line.
    always_comb begin
        raw          = '0;
        raw[IRQ_SVC] = svc_lvl;
        raw[IRQ_TMO] = tmo_q;
        raw[IRQ_OVR] = ovr_q;
        raw[IRQ_EOT] = eot_lvl;
        masked       = raw & mask;
        irq          = |masked;
    end
endmodule

// File: rtl/rx_status_fifo.sv
`timescale 1ns/1ps
// Receive buffer top: store, idle time-out timer and interrupt flags.
// Assumes push_valid, rd_en and irq_clr are one-cycle strobes in clk.
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 8,
    parameter int TO_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             bit_tick,
    input  logic             line_idle,
    input  logic             tx_done,
    input  logic             tx_empty,
    input  logic [IRQ_N-1:0] irq_mask,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic [IRQ_N-1:0] irq_raw,
    output logic [IRQ_N-1:0] irq_masked,
    output logic             irq
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    logic [CW-1:0] occ;
    logic          drop, expire, svc_lvl, eot_lvl, has_data;

    // Level conditions derived from occupancy and transmit status.
    always_comb begin
        svc_lvl  = (occ >= CW'(HALF));
        has_data = (occ != '0);
        eot_lvl  = tx_done && tx_empty;
    end

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push_valid), .push_data(push_data),
        .pop(rd_en), .rd_data(rd_data),
        .occ(occ), .drop(drop)
    );

    rxq_idle_timer #(.TO_BITS(TO_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .tick(bit_tick), .idle(line_idle), .has_data(has_data),
        .activity(push_valid || rd_en), .expire(expire)
    );

    rxq_irq_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .svc_lvl(svc_lvl), .tmo_set(expire), .ovr_set(drop), .eot_lvl(eot_lvl),
        .clr(irq_clr), .mask(irq_mask),
        .raw(irq_raw), .masked(irq_masked), .irq(irq)
    );
endmodule

// File: rtl/rx_status_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for rx_status_fifo, attached by bind below.
module rx_status_fifo_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_valid,
    input logic                       rd_en,
    input logic [WIDTH-1:0]           rd_data,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic [3:0]                 irq_mask,
    input logic [3:0]                 irq_clr,
    input logic [3:0]                 irq_raw,
    input logic                       irq
);
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH);
    a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        occ == 0 |-> rd_data == '0);
    a_r2_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 0 && rd_en && !push_valid) |=> occ == 0);
    a_r3_service_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raw[0] == (occ >= DEPTH/2));
    a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !rd_en && occ == DEPTH) |=> irq_raw[2]);
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[2] && !irq_clr[2]) |=> irq_raw[2]);
    a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rd_en && occ == DEPTH) |=> (occ == DEPTH && !$rose(irq_raw[2])));
    a_r6_push_blocks_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !$rose(irq_raw[1]));
    a_r6_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw[1]) |-> $past(occ) != 0);
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(irq_raw & irq_mask));
endmodule

bind rx_status_fifo rx_status_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .rd_en(rd_en),
    .rd_data(rd_data), .occ(occ), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .irq_raw(irq_raw), .irq(irq)
);

// File: tb/rx_status_fifo_bench.sv
`timescale 1ns/1ps
module rx_status_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        bit_tick = 1'b0;
    logic        line_idle = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_empty = 1'b0;
    logic [3:0]  irq_mask = '0;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq_raw, irq_masked;
    logic        irq;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    rx_status_fifo u_rx_status_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .rd_en(rd_en), .rd_data(rd_data), .bit_tick(bit_tick), .line_idle(line_idle),
        .tx_done(tx_done), .tx_empty(tx_empty), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push_word(input logic [15:0] d);
        push_valid = 1'b1; push_data = d;
        cyc();
        push_valid = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [15:0] exp);
        check(req, rd_data, exp);
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; cyc();
            bit_tick = 1'b0; cyc();
        end
    endtask

    task automatic clear(input logic [3:0] bits);
        irq_clr = bits; cyc(); irq_clr = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R10 raw flags", irq_raw, 0);
        check("R10 irq line", irq, 0);
        check("R10 empty data", rd_data, 0);
    endtask

    task automatic t_empty_read();
        check("R2 empty zero", rd_data, 0);
        rd_en = 1'b1; cyc(); rd_en = 1'b0;
        push_word(16'h5A5A);
        check("R2 push after empty read", rd_data, 16'h5A5A);
        pop_check("R1 single word", 16'h5A5A);
        check("R2 drained zero", rd_data, 0);
    endtask

    task automatic t_fill_overrun();
        for (int i = 0; i < 8; i++) begin
            push_word(16'hA000 + 16'(i));
            if (i == 2) check("R3 three words", irq_raw[0], 0);
            if (i == 3) check("R3 four words", irq_raw[0], 1);
        end
        check("R4 full no overrun yet", irq_raw[2], 0);
        // Push and read together while full.
        check("R5 oldest before swap", rd_data, 16'hA000);
        push_valid = 1'b1; push_data = 16'hA008; rd_en = 1'b1;
        cyc();
        push_valid = 1'b0; rd_en = 1'b0;
        check("R5 swap no overrun", irq_raw[2], 0);
        push_word(16'hDEAD);
        check("R4 overrun set", irq_raw[2], 1);
        cyc();
        check("R4 overrun sticky", irq_raw[2], 1);
        clear(4'b0001);
        check("R8 clear svc ignored", irq_raw[0], 1);
        check("R8 clear svc leaves ovr", irq_raw[2], 1);
        clear(4'b0100);
        check("R8 ovr cleared", irq_raw[2], 0);
        for (int i = 1; i <= 8; i++) begin
            pop_check("R1 order after swap", 16'hA000 + 16'(i));
            if (i == 4) check("R3 four left", irq_raw[0], 1);
            if (i == 5) check("R3 three left", irq_raw[0], 0);
        end
        check("R4 dropped word absent", rd_data, 0);
    endtask

    task automatic t_timeout();
        push_word(16'h1111);
        push_word(16'h2222);
        line_idle = 1'b1;
        tick_n(20);
        pop_check("R6 read restarts", 16'h1111);
        tick_n(31);
        check("R6 31 periods", irq_raw[1], 0);
        tick_n(1);
        check("R6 32 periods", irq_raw[1], 1);
        clear(4'b0010);
        check("R8 tmo cleared", irq_raw[1], 0);
        line_idle = 1'b0; cyc(); line_idle = 1'b1;
        tick_n(31);
        line_idle = 1'b0; cyc(); line_idle = 1'b1;
        tick_n(31);
        check("R6 busy line restarts", irq_raw[1], 0);
        tick_n(1);
        check("R6 fires after restart", irq_raw[1], 1);
        clear(4'b0010);
        pop_check("R1 second word", 16'h2222);
        tick_n(40);
        check("R6 empty never times out", irq_raw[1], 0);
        line_idle = 1'b0;
    endtask

    task automatic t_eot_mask();
        tx_done = 1'b1; tx_empty = 1'b0; cyc();
        check("R7 done only", irq_raw[3], 0);
        tx_empty = 1'b1; cyc();
        check("R7 done and empty", irq_raw[3], 1);
        irq_mask = 4'b0000; cyc();
        check("R9 all masked line", irq, 0);
        check("R9 all masked vec", irq_masked, 0);
        irq_mask = 4'b1000; cyc();
        check("R9 eot enabled line", irq, 1);
        check("R9 eot enabled vec", irq_masked, 4'b1000);
        irq_mask = 4'b0111; cyc();
        check("R9 other enables", irq, 0);
        clear(4'b1000);
        check("R8 clear eot ignored", irq_raw[3], 1);
        tx_done = 1'b0; cyc();
        check("R7 empty only", irq_raw[3], 0);
        tx_empty = 1'b0; irq_mask = '0;
    endtask

    initial begin
        #(200000 * 4);
        misses++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        t_reset();
        t_empty_read();
        t_fill_overrun();
        t_timeout();
        t_eot_mask();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule